// File: doc/BRIEF.md
# Lane Transmit Queue with Geometric Retry Back-off

This block is the sending side of one lane of a shared-receiver link on which collisions are allowed. Packets arrive on a ready/valid enqueue port and sit in a small first-in first-out queue. The head packet is driven onto the lane, always starting on a slot boundary. The block then listens for a single-bit confirmation during a fixed window. A confirmation frees the queue entry. If no confirmation arrives, the block treats the attempt as a collision and waits a random number of slots. The upper bound of that wait grows geometrically with each failed attempt. The block then sends the same packet again, and keeps retrying until it is confirmed.

The back-off bound is held in unsigned fixed point with eight fractional bits. It starts at 2.7 slots and is multiplied by 1.1 after every collision, with rounding. The wait is a uniform slot count below the rounded-up bound, drawn from a 16-bit LFSR. A status output shows the current attempt number.

Top module: `txq_backoff_top`

## Requirements
- R1: `enq_ready` is low exactly when the queue holds DEPTH packets. A word is accepted on a cycle where `enq_valid` and `enq_ready` are both high. An offer made while `enq_ready` is low is dropped and does not enter the queue.
- R2: Packets go onto the lane in acceptance order. A packet that is not confirmed is sent again with the same payload before any later packet.
- R3: The slot counter is zero in the first cycle after reset and advances once per cycle modulo SLOT_LEN. `lane_valid` rises only in a cycle where that counter is zero.
- R4: A transmission holds `lane_valid` high for PKT_CYC consecutive cycles with `lane_data` constant and equal to the head payload. `lane_data` is zero whenever `lane_valid` is low.
- R5: The confirmation window is the PKT_CYC+2 cycles that begin with the first `lane_valid` cycle. A high `confirm` in any of those cycles removes the head packet. In the next cycle `retry_count` is 1 and `lane_valid` is low.
- R6: `confirm` outside a window is ignored. The queue and `retry_count` are unchanged, and the same head packet is sent again.
- R7: If a window ends without a confirmation, `retry_count` increases by one in the next cycle, saturating at 255.
- R8: The bound W_r in Q8 starts at W_1 = 691 and follows W_(r+1) = min((11·W_r + 5) / 10, 65280), using integer division. After attempt r fails, at most ceil(W_r / 256) slot boundaries pass before the retransmission starts.
- R9: While reset is high, `enq_ready` is 1, `lane_valid` is 0, `lane_data` is 0 and `retry_count` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request |
| enq_data | input | DW | Packet payload to enqueue |
| enq_ready | output | 1 | Queue can accept a packet |
| lane_valid | output | 1 | Lane carries a packet this cycle |
| lane_data | output | DW | Lane payload |
| confirm | input | 1 | Confirmation from the dedicated confirmation lane |
| retry_count | output | 8 | Attempt number of the head packet, 1 after a confirmation |

## Verification
Some properties are checked by the assertions on every cycle. A refused offer leaves the occupancy unchanged. Every lane start falls on slot phase zero. The payload holds steady during a transmission. A confirmation inside the window clears the attempt count and the lane. A stray confirmation leaves the count alone. A failed window steps the count by exactly one. Other properties only the bench scenarios can show. These are the acceptance order across retries and full-queue refusals, and the survival of the head packet through stray confirmations. They also include the back-off bound as it grows over more than fifty consecutive collisions, and the clean drain of the queue under confirmations at the first, middle and last cycle of the window.

// File: rtl/txb_pkg.sv
package txb_pkg;

    localparam int          WIN_FRAC   = 8;
    localparam logic [15:0] WIN_INIT   = 16'd691;    // 2.7 in Q8.8
    localparam logic [15:0] WIN_MAX    = 16'hFF00;   // 255 slots
    localparam logic [15:0] LFSR_TAPS  = 16'hB400;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_BACKOFF = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [15:0] win;
        logic [7:0]  attempt;
    } bo_state_t;

    // grow the window by 1.1 with rounding, saturating at WIN_MAX
    function automatic logic [15:0] win_grow(input logic [15:0] w);
        logic [19:0] scaled;
        logic [19:0] quot;
        scaled = ({4'd0, w} * 20'd11) + 20'd5;
        quot   = scaled / 20'd10;
        if (quot > {4'd0, WIN_MAX})
            return WIN_MAX;
        return quot[15:0];
    endfunction

    // round the Q8 window up to a whole slot count
    function automatic logic [7:0] win_ceil(input logic [15:0] w);
        logic [16:0] sum;
        sum = {1'b0, w} + 17'd255;
        return sum[15:8];
    endfunction

    // uniform draw in [0, lim) from a 16-bit random word
    function automatic logic [7:0] scale_draw(input logic [15:0] rnd,
                                              input logic [7:0]  lim);
        logic [23:0] prod;
        prod = {8'd0, rnd} * {16'd0, lim};
        return prod[23:16];
    endfunction

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    assign full  = (count == CNT_FULL);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (push && (wr_ptr == AW'(i))) begin
                    mem[i] <= din;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/txb_slot.sv
module txb_slot #(
    parameter int SLOT_LEN = 4,
    localparam int SW      = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] phase,
    output logic          pre_edge
);
    localparam logic [SW-1:0] PH_LAST = SW'(SLOT_LEN - 1);

    assign pre_edge = (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (pre_edge)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/txb_lfsr.sv
module txb_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] rnd
);
    import txb_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            rnd <= SEED;
        else if (rnd[0])
            rnd <= (rnd >> 1) ^ LFSR_TAPS;
        else
            rnd <= rnd >> 1;
    end

endmodule

// File: rtl/txb_backoff.sv
module txb_backoff (
    input  logic        clk,
    input  logic        rst,
    input  logic        collide,
    input  logic        accept,
    input  logic [15:0] rnd,
    output logic [7:0]  attempt,
    output logic [7:0]  draw
);
    import txb_pkg::*;

    bo_state_t cur;

    assign attempt = cur.attempt;
    assign draw    = scale_draw(rnd, win_ceil(cur.win));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.win     <= WIN_INIT;
            cur.attempt <= 8'd1;
        end else if (accept) begin
            cur.win     <= WIN_INIT;
            cur.attempt <= 8'd1;
        end else if (collide) begin
            cur.win     <= win_grow(cur.win);
            cur.attempt <= (cur.attempt == 8'hFF) ? 8'hFF : cur.attempt + 8'd1;
        end
    end

endmodule

// File: rtl/txq_backoff_top.sv
module txq_backoff_top #(
    parameter int          DW       = 8,
    parameter int          DEPTH    = 8,
    parameter int          PKT_CYC  = 3,
    parameter int          SLOT_LEN = 4,
    parameter logic [15:0] SEED     = 16'hACE1,
    localparam int         CW       = $clog2(DEPTH + 1),
    localparam int         SW       = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1,
    localparam int         WW       = $clog2(PKT_CYC + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_valid,
    input  logic [DW-1:0] enq_data,
    output logic          enq_ready,
    output logic          lane_valid,
    output logic [DW-1:0] lane_data,
    input  logic          confirm,
    output logic [7:0]    retry_count
);
    import txb_pkg::*;

    localparam logic [WW-1:0] WIN_LAST = WW'(PKT_CYC + 1);
    localparam logic [WW-1:0] SEND_END = WW'(PKT_CYC);

    tx_state_e     st;
    logic [WW-1:0] win_cnt;
    logic [7:0]    bo_cnt;
    logic [7:0]    draw;
    logic [15:0]   rnd;
    logic [SW-1:0] slot_cnt;
    logic          slot_pre;
    logic [DW-1:0] q_head;
    logic          q_full;
    logic          q_empty;
    logic [CW-1:0] q_cnt;
    logic          q_push;
    logic          q_pop;
    logic          win_open;
    logic          collide;

    assign enq_ready  = !q_full;
    assign q_push     = enq_valid && !q_full;
    assign win_open   = (st == ST_ACTIVE);
    assign q_pop      = win_open && confirm;
    assign collide    = win_open && !confirm && (win_cnt == WIN_LAST);
    assign lane_valid = win_open && (win_cnt < SEND_END);
    assign lane_data  = lane_valid ? q_head : '0;

    txb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (enq_data),
        .pop   (q_pop),
        .head  (q_head),
        .full  (q_full),
        .empty (q_empty),
        .count (q_cnt)
    );

    txb_slot #(.SLOT_LEN(SLOT_LEN)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .phase    (slot_cnt),
        .pre_edge (slot_pre)
    );

    txb_lfsr #(.SEED(SEED)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    txb_backoff u_bo (
        .clk     (clk),
        .rst     (rst),
        .collide (collide),
        .accept  (q_pop),
        .rnd     (rnd),
        .attempt (retry_count),
        .draw    (draw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            win_cnt <= '0;
            bo_cnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (!q_empty && slot_pre) begin
                        st      <= ST_ACTIVE;
                        win_cnt <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (confirm) begin
                        st <= ST_IDLE;
                    end else if (win_cnt == WIN_LAST) begin
                        st     <= ST_BACKOFF;
                        bo_cnt <= draw;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_BACKOFF: begin
                    if (slot_pre) begin
                        if (bo_cnt == 8'd0) begin
                            st      <= ST_ACTIVE;
                            win_cnt <= '0;
                        end else begin
                            bo_cnt <= bo_cnt - 8'd1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
    parameter int DW       = 8,
    parameter int CW       = 4,
    parameter int SW       = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          enq_valid,
    input logic          enq_ready,
    input logic          lane_valid,
    input logic [DW-1:0] lane_data,
    input logic          confirm,
    input logic [7:0]    retry_count,
    input logic [SW-1:0] slot_cnt,
    input logic          win_open,
    input logic          collide,
    input logic          q_pop,
    input logic [CW-1:0] q_cnt
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && !enq_ready && !q_pop) |=> $stable(q_cnt)); // R1

    AST_SLOT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(lane_valid) |-> (slot_cnt == '0)); // R3

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && $past(lane_valid)) |-> $stable(lane_data)); // R4

    AST_CONF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (confirm && win_open) |=> (retry_count == 8'd1 && !lane_valid)); // R5

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (confirm && !win_open) |=> $stable(retry_count)); // R6

    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (rst)
        collide |=> (retry_count == (($past(retry_count) == 8'hFF) ?
                                     8'hFF : $past(retry_count) + 8'd1))); // R7

endmodule

bind txq_backoff_top txb_checker #(.DW(DW), .CW(CW), .SW(SW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enq_valid   (enq_valid),
    .enq_ready   (enq_ready),
    .lane_valid  (lane_valid),
    .lane_data   (lane_data),
    .confirm     (confirm),
    .retry_count (retry_count),
    .slot_cnt    (slot_cnt),
    .win_open    (win_open),
    .collide     (collide),
    .q_pop       (q_pop),
    .q_cnt       (q_cnt)
);

// File: tb/sim_txq_backoff_top.sv
`timescale 1ns/1ps
module sim_txq_backoff_top;

    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int P     = 3;
    localparam int SLOT  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [DW-1:0] enq_data  = '0;
    logic          enq_ready;
    logic          lane_valid;
    logic [DW-1:0] lane_data;
    logic          confirm = 1'b0;
    logic [7:0]    retry_count;

    always #10 clk = ~clk;

    txq_backoff_top #(.DW(DW), .DEPTH(DEPTH), .PKT_CYC(P), .SLOT_LEN(SLOT)) u0 (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_data(enq_data),
        .enq_ready(enq_ready), .lane_valid(lane_valid), .lane_data(lane_data),
        .confirm(confirm), .retry_count(retry_count)
    );

    int checks = 0;
    int failures = 0;
    bit run = 0;
    bit done = 0;

    // reference queue and back-off model
    int q_mem [0:255];
    int q_wr = 0;
    int q_rd = 0;
    int exp_retry = 1;
    int exp_w = 691;

    // monitor state
    int  cyc = 0;
    bit  active = 0;
    int  off = 0;
    int  cur_pay = 0;
    bit  retx_pend = 0;
    int  skipped = 0;
    int  skip_lim = 0;
    bit  chk_conf_next = 0;
    bit  chk_to_next = 0;
    bit  cmode = 0;
    int  coff = 0;
    bit  stray = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(negedge clk) begin
        if (run) begin
            int phase;
            phase = cyc % SLOT;
            confirm = 1'b0;
            if (chk_conf_next) begin
                chk(retry_count == 8'd1, "R5 retry after confirm", retry_count, 1);
                chk(!lane_valid, "R5 lane idle after confirm", lane_valid, 0);
                chk_conf_next = 0;
            end
            if (chk_to_next) begin
                chk(retry_count == 8'(exp_retry), "R7 retry step", retry_count, exp_retry);
                if (stray) confirm = 1'b1;  // outside any window: R6
                chk_to_next = 0;
            end
            if (!active && !lane_valid) begin
                chk(lane_data == '0, "R4 idle lane data", lane_data, 0);
                if (retx_pend && phase == 0) skipped++;
            end
            if (!active && lane_valid) begin
                chk(phase == 0, "R3 start phase", phase, 0);
                chk(q_wr != q_rd, "R2 send from non-empty", q_wr - q_rd, 1);
                cur_pay = q_mem[q_rd % 256];
                chk(lane_data == DW'(cur_pay), "R2 head payload", lane_data, cur_pay);
                if (retx_pend)
                    chk(skipped <= skip_lim, "R8 backoff bound", skipped, skip_lim);
                retx_pend = 0;
                active = 1;
                off = 0;
            end
            if (active) begin
                if (off < P) begin
                    chk(lane_valid && lane_data == DW'(cur_pay), "R4 hold",
                        lane_data, cur_pay);
                end else begin
                    chk(!lane_valid, "R4 length", lane_valid, 0);
                end
                if (cmode && off == coff) confirm = 1'b1;
                if (confirm) begin
                    q_rd++;
                    exp_retry = 1;
                    exp_w = 691;
                    active = 0;
                    chk_conf_next = 1;
                end else if (off == P + 1) begin
                    retx_pend = 1;
                    skipped = 0;
                    skip_lim = (exp_w + 255) / 256;
                    exp_w = (exp_w * 11 + 5) / 10;
                    if (exp_w > 65280) exp_w = 65280;
                    if (exp_retry < 255) exp_retry++;
                    active = 0;
                    chk_to_next = 1;
                end
                off++;
            end
            cyc++;
        end
    end

    task automatic enqueue(input int val);
        forever begin
            @(negedge clk); #1;
            enq_valid = 1'b1;
            enq_data  = DW'(val);
            if (enq_ready) begin
                q_mem[q_wr % 256] = val;
                q_wr++;
                @(posedge clk); #1;
                enq_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic drain();
        while (q_wr != q_rd || active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_up();
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(enq_ready == 1'b1, "R9 ready", enq_ready, 1);
        chk(lane_valid == 1'b0, "R9 lane_valid", lane_valid, 0);
        chk(lane_data == '0, "R9 lane_data", lane_data, 0);
        chk(retry_count == 8'd1, "R9 retry", retry_count, 1);
        @(posedge clk); #1;
        rst = 1'b0;
        run = 1;

        // fill without confirmations: R1 full, R2 ordering, R7/R8 growth
        for (int i = 0; i < DEPTH; i++) enqueue(8'h10 + i);
        @(negedge clk);
        chk(enq_ready == 1'b0, "R1 full", enq_ready, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            enq_valid = 1'b1;
            enq_data  = 8'hEE;
            chk(enq_ready == 1'b0, "R1 refused", enq_ready, 0);
        end
        @(negedge clk); #1;
        enq_valid = 1'b0;
        while (exp_retry < 55) @(negedge clk);

        // confirm at last window cycle, drain all eight in order
        cmode = 1;
        coff = P + 1;
        drain();
        chk(enq_ready == 1'b1, "R1 ready after drain", enq_ready, 1);

        // confirm in the first window cycle
        coff = 0;
        for (int i = 0; i < 4; i++) enqueue(8'h40 + i);
        drain();

        // confirm in the middle of the window
        coff = 2;
        for (int i = 0; i < 3; i++) enqueue(8'h60 + i);
        drain();

        // stray confirmations between attempts: R6
        cmode = 0;
        stray = 1;
        enqueue(8'hA5);
        enqueue(8'hA6);
        while (exp_retry < 4) @(negedge clk);
        stray = 0;
        cmode = 1;
        coff = P;
        drain();
        chk(retry_count == 8'd1, "R5 final retry", retry_count, 1);
        chk(q_rd == q_wr, "R2 all delivered", q_rd, q_wr);

        done = 1;
        finish_up();
    end

endmodule